// File: doc/BRIEF.md
# Bus Cycle Ready Generator

This block produces the active-low ready line that ends a processor bus cycle. Two ready sources feed it. The first is a synchronous pair: a ready input and its enable, both active low. The second is an asynchronous pair with the same shape. The asynchronous pair first passes through a two-stage synchronizer. All state changes on the falling edge of the system clock. Sources are looked at only while the half-rate processor phase input is high. The synchronous pair is also looked at only while both bus status lines are idle (high).

The ready line is open-drain, so the block never drives it high. It presents two signals, `drive_low` and `oe`, and the wire is low only when both are set; an external pull-up returns it high otherwise. When either status line is seen low, the block releases the wire, so that each new bus cycle starts with ready inactive. Once ready is asserted it is held for at least two clocks. Reset forces ready active.

The controller has four states:
- `ST_FORCE`: driving, while reset is seen.
- `ST_FLOAT`: released.
- `ST_HOLD_FIRST`: first driven clock.
- `ST_HOLD`: continued drive.

Transitions:
- Any state goes to `ST_FORCE` when reset is seen.
- `ST_FORCE` goes to `ST_FLOAT` when reset is gone.
- `ST_FLOAT` goes to `ST_HOLD_FIRST` on a qualified hit.
- `ST_HOLD_FIRST` goes to `ST_HOLD` unconditionally.
- `ST_HOLD` goes to `ST_FLOAT` on busy status, or when the phase is high and no source is active.
- `ST_HOLD` stays in `ST_HOLD` otherwise.

Top module: `bus_ready_gen`

## Requirements
- R1: With both status lines high and the phase high, a synchronous pair sampled both low on a falling edge makes the block drive ready from that edge on. Any other synchronous pair value leaves ready released.
- R2: The synchronous pair is not looked at while the phase is low, or while either status line is low.
- R3: The asynchronous pair passes through two falling-edge stages. A pair held low from before edge 1 first drives ready after edge 3. It is honoured only while the phase is high.
- R4: While the synchronized asynchronous pair is active and the phase is high, ready is asserted whatever the synchronous pair holds.
- R5: From continued drive (second and later driven clocks), either status line sampled low releases ready at that edge, even with a source still active.
- R6: Once asserted, ready stays driven for at least two falling edges, even if status goes low or both sources drop.
- R7: During continued drive, ready is kept while the phase is low. It is released at the first phase-high edge on which neither source is active.
- R8: A falling edge that sees reset high makes ready driven. The first edge after reset drops releases it.
- R9: Encoding: driving means `drive_low`=1 and `oe`=1; released means both are 0. The resolved wire is 0 only when both are 1.
- R10: After a release caused by status, a new cycle can assert ready again as soon as status returns idle and a source is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| phase_hi | input | 1 | Half-rate processor phase; sources are looked at only while high |
| stat_n | input | 2 | Bus status lines, active low; any low bit means a cycle is starting |
| srdy_n | input | 1 | Synchronous ready, active low |
| srdy_en_n | input | 1 | Enable for the synchronous ready, active low |
| ardy_n | input | 1 | Asynchronous ready, active low |
| ardy_en_n | input | 1 | Enable for the asynchronous ready, active low |
| drive_low | output | 1 | Value to drive: 1 pulls the ready wire low |
| oe | output | 1 | Output enable of the open-drain driver |

## Verification
The bench covers every synchronous-pair value, and every status and phase combination that must block the synchronous path. A design that ignored the phase or the status gate would assert ready in those sweeps.

It measures the asynchronous latency edge by edge. It also re-applies every synchronous value while the asynchronous pair is active. This exposes a missing synchronizer stage, an off-by-one stage, or a synchronous pair that overrides the asynchronous one.

Status going low straight after assertion and after two driven clocks separates the minimum hold from the release. A release that did not wait for a phase-high edge shows up early. Reset asserted during a hold with busy status shows whether reset takes precedence.

// File: rtl/brg_pkg.sv
package brg_pkg;
    typedef enum logic [1:0] {
        ST_FLOAT      = 2'd0,
        ST_FORCE      = 2'd1,
        ST_HOLD_FIRST = 2'd2,
        ST_HOLD       = 2'd3
    } brg_state_t;
endpackage

// File: rtl/brg_sync.sv
// Multi-stage falling-edge synchronizer for the asynchronous ready pair.
module brg_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(negedge clk) begin
                if (rst) stg[i] <= '1;
                else     stg[i] <= d_in;
            end
        end else begin : g_next
            always_ff @(negedge clk) begin
                if (rst) stg[i] <= '1;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/brg_qual.sv
// Qualifies both ready sources with phase and status; async path wins.
module brg_qual #(
    parameter int STAT_W = 2
) (
    input  logic              phase_hi,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              srdy_n,
    input  logic              srdy_en_n,
    input  logic [1:0]        async_q,
    output logic              status_busy,
    output logic              any_hit
);
    logic sync_ok;
    logic async_ok;

    always_comb begin
        status_busy = ~(&stat_n);
        sync_ok     = ~srdy_n & ~srdy_en_n & ~status_busy & phase_hi;
        async_ok    = ~async_q[0] & ~async_q[1] & phase_hi;
        if (async_ok) any_hit = 1'b1;   // synchronous pair not consulted
        else          any_hit = sync_ok;
    end
endmodule

// File: rtl/brg_fsm.sv
// Ready hold controller: state register, next-state logic, output logic.
module brg_fsm
    import brg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase_hi,
    input  logic status_busy,
    input  logic any_hit,
    output logic drv
);
    brg_state_t state;
    brg_state_t nxt;

    always_ff @(negedge clk) begin
        state <= nxt;
    end

    always_comb begin
        nxt = ST_FLOAT;
        if (rst) begin
            nxt = ST_FORCE;
        end else begin
            unique case (state)
                ST_FORCE:      nxt = ST_FLOAT;
                ST_FLOAT:      nxt = (!status_busy && any_hit) ? ST_HOLD_FIRST : ST_FLOAT;
                ST_HOLD_FIRST: nxt = ST_HOLD;
                ST_HOLD: begin
                    if (status_busy)               nxt = ST_FLOAT;
                    else if (phase_hi && !any_hit) nxt = ST_FLOAT;
                    else                           nxt = ST_HOLD;
                end
                default:       nxt = ST_FLOAT;
            endcase
        end
    end

    always_comb begin
        drv = (state != ST_FLOAT);
    end

    // R8: reset seen on an edge means ready driven after it
    a_r8_reset_force: assert property (@(negedge clk) rst |=> drv);

    // R6: at least two driven edges after assertion
    a_r6_min_hold: assert property (@(negedge clk) disable iff (rst)
        $rose(drv) |=> drv);

    // R5: busy status in continued drive releases the wire
    a_r5_float_on_status: assert property (@(negedge clk) disable iff (rst)
        (state == ST_HOLD && status_busy) |=> !drv);

    // R7: release on phase-high edge with no active source
    a_r7_release: assert property (@(negedge clk) disable iff (rst)
        (state == ST_HOLD && !status_busy && phase_hi && !any_hit) |=> !drv);

    // R2: no assertion from released state while phase is low
    a_r2_phase_gate: assert property (@(negedge clk) disable iff (rst)
        (state == ST_FLOAT && !phase_hi) |=> !drv);
endmodule

// File: rtl/bus_ready_gen.sv
module bus_ready_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int STAT_W      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_hi,
    input  logic [STAT_W-1:0] stat_n,
    input  logic              srdy_n,
    input  logic              srdy_en_n,
    input  logic              ardy_n,
    input  logic              ardy_en_n,
    output logic              drive_low,
    output logic              oe
);
    logic [1:0] async_q;
    logic       status_busy;
    logic       any_hit;
    logic       drv;

    brg_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({ardy_en_n, ardy_n}),
        .q_out (async_q)
    );

    brg_qual #(.STAT_W(STAT_W)) u_qual (
        .phase_hi    (phase_hi),
        .stat_n      (stat_n),
        .srdy_n      (srdy_n),
        .srdy_en_n   (srdy_en_n),
        .async_q     (async_q),
        .status_busy (status_busy),
        .any_hit     (any_hit)
    );

    brg_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .phase_hi    (phase_hi),
        .status_busy (status_busy),
        .any_hit     (any_hit),
        .drv         (drv)
    );

    assign drive_low = drv;
    assign oe        = drv;
endmodule

// File: tb/sim_bus_ready_gen.sv
module sim_bus_ready_gen;
    logic       clk = 1'b0;
    logic       rst;
    logic       phase_hi;
    logic [1:0] stat_n;
    logic       srdy_n, srdy_en_n, ardy_n, ardy_en_n;
    logic       drive_low, oe;
    logic       ready_wire;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bus_ready_gen u0 (
        .clk(clk), .rst(rst), .phase_hi(phase_hi), .stat_n(stat_n),
        .srdy_n(srdy_n), .srdy_en_n(srdy_en_n), .ardy_n(ardy_n),
        .ardy_en_n(ardy_en_n), .drive_low(drive_low), .oe(oe)
    );

    // pull-up resolution of the open-drain wire (R9)
    assign ready_wire = (drive_low && oe) ? 1'b0 : 1'b1;

    task automatic tick();
        @(negedge clk);
        @(posedge clk);
    endtask

    task automatic chk(input bit exp_drv, input string req);
        logic exp_wire;
        exp_wire = exp_drv ? 1'b0 : 1'b1;
        n_chk++;
        if (drive_low !== exp_drv || oe !== exp_drv || ready_wire !== exp_wire) begin
            n_bad++;
            $display("FAIL %s: drive_low=%b oe=%b wire=%b expected drive_low=%b oe=%b wire=%b",
                     req, drive_low, oe, ready_wire, exp_drv, exp_drv, exp_wire);
        end
    endtask

    task automatic idle_inputs();
        phase_hi = 1'b1; stat_n = 2'b11;
        srdy_n = 1'b1; srdy_en_n = 1'b1; ardy_n = 1'b1; ardy_en_n = 1'b1;
    endtask

    initial begin
        rst = 1'b1;
        idle_inputs();
        tick();
        chk(1'b1, "R8 reset forces ready");
        tick();
        chk(1'b1, "R8 reset held");
        rst = 1'b0;
        tick();
        chk(1'b0, "R8 release after reset");

        // R1: sweep synchronous pair
        for (int v = 0; v < 4; v++) begin
            idle_inputs();
            srdy_n = v[0]; srdy_en_n = v[1];
            tick();
            chk(v == 0, "R1 sync pair sweep");
            if (v == 0) begin
                stat_n = 2'b01; srdy_n = 1'b1; srdy_en_n = 1'b1;
                tick();
                chk(1'b1, "R6 min hold despite status");
                tick();
                chk(1'b0, "R5 status release");
            end
            idle_inputs();
            tick();
            chk(1'b0, "R1 idle between sweeps");
        end

        // R2: every blocking status/phase combination
        for (int c = 0; c < 8; c++) begin
            if (c != 7) begin
                idle_inputs();
                stat_n = c[1:0]; phase_hi = c[2];
                srdy_n = 1'b0; srdy_en_n = 1'b0;
                tick();
                chk(1'b0, "R2 sync path gated");
            end
        end
        idle_inputs();
        tick();
        chk(1'b0, "R2 back to idle");

        // R3: async latency and R7 hold/release
        ardy_n = 1'b0; ardy_en_n = 1'b0;
        tick(); chk(1'b0, "R3 edge1 not yet");
        tick(); chk(1'b0, "R3 edge2 not yet");
        tick(); chk(1'b1, "R3 edge3 driven");
        tick(); chk(1'b1, "R6 second driven edge");
        ardy_n = 1'b1; ardy_en_n = 1'b1; phase_hi = 1'b0;
        tick(); chk(1'b1, "R7 hold while phase low");
        tick(); chk(1'b1, "R7 hold while phase low 2");
        phase_hi = 1'b1;
        tick(); chk(1'b0, "R7 release on phase high");

        // R3/R4: async synced under phase low, then sync sweep with phase high
        idle_inputs();
        ardy_n = 1'b0; ardy_en_n = 1'b0; phase_hi = 1'b0;
        tick(); tick(); tick();
        chk(1'b0, "R3 async gated by phase");
        for (int v = 0; v < 4; v++) begin
            phase_hi = 1'b1; srdy_n = v[0]; srdy_en_n = v[1];
            tick();
            chk(1'b1, "R4 async wins over sync pair");
            stat_n = 2'b10;
            tick(); chk(1'b1, "R6 min hold");
            tick(); chk(1'b0, "R5 status release with async active");
            stat_n = 2'b11; phase_hi = 1'b0;
            tick(); chk(1'b0, "R4 idle between");
        end
        idle_inputs();
        phase_hi = 1'b0;
        tick(); tick();
        idle_inputs();

        // R10: back-to-back cycles with source held
        srdy_n = 1'b0; srdy_en_n = 1'b0;
        tick(); chk(1'b1, "R10 first cycle");
        tick(); chk(1'b1, "R10 continued drive");
        stat_n = 2'b10;
        tick(); chk(1'b0, "R5 release with source active");
        stat_n = 2'b11;
        tick(); chk(1'b1, "R10 next cycle asserts");

        // R8: reset during hold with busy status
        tick(); chk(1'b1, "R10 held");
        rst = 1'b1; stat_n = 2'b00;
        tick(); chk(1'b1, "R8 reset over busy status");
        rst = 1'b0; idle_inputs();
        tick(); chk(1'b0, "R8 release after mid-hold reset");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule